// File: doc/BRIEF.md
# Per-CPU Inter-Processor Interrupt Unit

This unit gives each of `N` processors two inter-processor interrupt channels, called "other" and "self". Each processor has its own register access port into the unit. The index of the port identifies the processor making the access.

A processor can raise the "other" channel on any set of processors with a single write. It can raise its own "self" channel, or it can set either channel on a chosen processor through that processor's explicit register window. For every processor the unit keeps a pending bit and a mask bit per channel. A live request is one that is pending and not masked. Live requests drive that processor's interrupt line and are reported through an event register.

Reading the event register reports one live channel and masks that channel automatically. The pending bit is not touched by the read. Software clears the pending bit with an acknowledge write, then re-enables the channel with a mask-clear write. Pending state and mask state each have their own write-one-to-act registers, so software never performs read-modify-write on shared state. `N` must lie between 2 and 31.

Top module: `ipi_unit`

## Requirements
- R1: After reset, no channel is pending and both channels are masked on every processor. Every interrupt line is low, and every event read returns 0.
- R2: The default-view send register sits at 0x2008. A write with bit k set (k < N) makes the "other" channel pending on processor k. One write may target several processors.
- R3: Bit 31 of a default-view send write makes the "self" channel pending on the writing processor. In processor c's explicit set register, bit 0 sets "other" and bit 31 sets "self" on processor c.
- R4: The event register (default view 0x2004) returns 0x00040001 when "other" is reported and 0x00040002 when "self" is reported. It returns 0 when no channel is live.
- R5: When both channels are live, "other" is reported before "self".
- R6: An event read that reports a channel sets that channel's mask bit from the next cycle and leaves the pending bit unchanged. A read that reports nothing changes no state.
- R7: An acknowledge write (default view 0x200C) clears pending bits of the target processor: bit 0 for "other", bit 31 for "self".
- R8: A mask-set write (0x2024) masks channels and a mask-clear write (0x2028) unmasks them, using bit 0 for "other" and bit 31 for "self". A masked pending channel is neither reported nor signalled. It becomes live again once it is unmasked.
- R9: Default-view registers act on the accessing processor. The explicit view for processor c is at the default offset plus 0x3000 + (c << 7). Explicit accesses for c >= N have no effect.
- R10: If a set and an acknowledge for the same channel of the same processor land in the same cycle, the channel stays pending.
- R11: `irq_o[c]` is high exactly when processor c has at least one live channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | N | Per-processor access strobe |
| bus_write | input | N | Per-processor access is a write when high |
| bus_addr | input | N*ADDR_W | Per-processor byte address, port p in slice p |
| bus_wdata | input | N*32 | Per-processor write data |
| bus_rdata | output | N*32 | Per-processor read data, valid in the access cycle |
| irq_o | output | N | Per-processor interrupt request |

## Verification
The bench targets the cases where the two channels interact. With both channels live, a design that reversed the priority would report 2 first. A design that cleared pending on read instead of masking would drop the second report and lower the line too early.

It checks that a masked pending request stays hidden and then reappears on mask-clear. A design that discarded requests while they were masked would never raise the line again. It also sends an explicit-view write to a processor number past `N`, which catches an index that wraps onto processor 0.

Finally, a send and an acknowledge are issued in the same cycle for the same processor. A design with clear priority over set would lose that request.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned CH_OTHER  = 0;
    localparam int unsigned CH_SELF   = 1;
    localparam int unsigned SELF_BIT  = 31;
    localparam int unsigned DFLT_BASE = 'h2000;
    localparam int unsigned EXPL_BASE = 'h5000;
    localparam int unsigned WIN_SHIFT = 7;
    localparam logic [6:0] REG_EVT   = 7'h04;
    localparam logic [6:0] REG_SET   = 7'h08;
    localparam logic [6:0] REG_ACK   = 7'h0C;
    localparam logic [6:0] REG_MSET  = 7'h24;
    localparam logic [6:0] REG_MCLR  = 7'h28;
    localparam logic [15:0] EVT_KIND_IPI = 16'd4;

    typedef struct packed {
        logic [1:0] pend;
        logic [1:0] mask;
    } chan_state_t;

    function automatic logic [WORD_W-1:0] evt_word(input logic [1:0] live);
        if (live[CH_OTHER])     return {EVT_KIND_IPI, 16'd1};
        else if (live[CH_SELF]) return {EVT_KIND_IPI, 16'd2};
        else                    return '0;
    endfunction
endpackage

// File: rtl/ipi_port_decode.sv
module ipi_port_decode
    import ipi_pkg::*;
#(
    parameter int N      = 4,
    parameter int ADDR_W = 16,
    parameter int PORT   = 0,
    localparam int CW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [1:0]        set_o  [N],
    output logic [1:0]        clr_o  [N],
    output logic [1:0]        mset_o [N],
    output logic [1:0]        mclr_o [N],
    output logic [N-1:0]      evt_rd_o,
    output logic              evt_hit_o,
    output logic [CW-1:0]     evt_tgt_o
);
    localparam logic [ADDR_W-8:0] DFLT_PAGE = (ADDR_W-7)'(DFLT_BASE >> WIN_SHIFT);
    localparam logic [ADDR_W-1:0] EXPL_ADDR = ADDR_W'(EXPL_BASE);

    logic              hit_d, dflt_d;
    logic [CW-1:0]     tgt_d;
    logic [6:0]        rsel_d;
    logic [ADDR_W-1:0] off_d, idx_d;
    logic [1:0]        chbits_d;
    logic              unused_wdata;

    assign unused_wdata = ^wdata_i;
    assign chbits_d     = {wdata_i[SELF_BIT], wdata_i[0]};

    always_comb begin
        hit_d  = 1'b0;
        dflt_d = 1'b0;
        tgt_d  = '0;
        rsel_d = '0;
        off_d  = addr_i - EXPL_ADDR;
        idx_d  = off_d >> WIN_SHIFT;
        if (addr_i[ADDR_W-1:7] == DFLT_PAGE) begin
            hit_d  = 1'b1;
            dflt_d = 1'b1;
            tgt_d  = CW'(PORT);
            rsel_d = addr_i[6:0];
        end else if (addr_i >= EXPL_ADDR && idx_d < ADDR_W'(N)) begin
            hit_d  = 1'b1;
            tgt_d  = CW'(idx_d);
            rsel_d = off_d[6:0];
        end
    end

    always_comb begin
        for (int c = 0; c < N; c++) begin
            set_o[c]  = '0;
            clr_o[c]  = '0;
            mset_o[c] = '0;
            mclr_o[c] = '0;
        end
        evt_rd_o  = '0;
        evt_hit_o = 1'b0;
        evt_tgt_o = tgt_d;
        if (valid_i && hit_d) begin
            if (write_i) begin
                case (rsel_d)
                    REG_SET: begin
                        if (dflt_d) begin
                            for (int k = 0; k < N; k++) set_o[k][CH_OTHER] = wdata_i[k];
                            set_o[tgt_d][CH_SELF] = wdata_i[SELF_BIT];
                        end else begin
                            set_o[tgt_d] = chbits_d;
                        end
                    end
                    REG_ACK:  clr_o[tgt_d]  = chbits_d;
                    REG_MSET: mset_o[tgt_d] = chbits_d;
                    REG_MCLR: mclr_o[tgt_d] = chbits_d;
                    default: ;
                endcase
            end else if (rsel_d == REG_EVT) begin
                evt_rd_o[tgt_d] = 1'b1;
                evt_hit_o       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ipi_chan_bank.sv
module ipi_chan_bank
    import ipi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] set_i,
    input  logic [1:0] clr_i,
    input  logic [1:0] mset_i,
    input  logic [1:0] mclr_i,
    input  logic [1:0] deliver_i,
    output logic [1:0] pend_o,
    output logic [1:0] mask_o
);
    chan_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // set is applied after clear so a colliding request survives
        st_d.pend = (st_q.pend & ~clr_i) | set_i;
        // masking (explicit or by delivery) wins over a same-cycle unmask
        st_d.mask = (st_q.mask & ~mclr_i) | mset_i | deliver_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend <= 2'b00;
            st_q.mask <= 2'b11;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign mask_o = st_q.mask;

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[CH_OTHER] && !set_i[CH_OTHER]) |=> !pend_o[CH_OTHER]);
    p_set_survives_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i[CH_SELF] && clr_i[CH_SELF]) |=> pend_o[CH_SELF]);
    p_deliver_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_i != 2'b00) |=> ((mask_o & $past(deliver_i)) == $past(deliver_i)));
    p_deliver_keeps_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (deliver_i != 2'b00 && clr_i == 2'b00) |=> ((pend_o & $past(deliver_i)) == $past(deliver_i)));
    p_mset_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mset_i[CH_SELF] |=> mask_o[CH_SELF]);
endmodule

// File: rtl/ipi_evt_sel.sv
module ipi_evt_sel
    import ipi_pkg::*;
(
    input  logic [1:0]        pend_i,
    input  logic [1:0]        mask_i,
    input  logic              rd_i,
    output logic [WORD_W-1:0] word_o,
    output logic [1:0]        deliver_o,
    output logic              irq_o
);
    logic [1:0] live;

    always_comb begin
        live      = pend_i & ~mask_i;
        word_o    = evt_word(live);
        irq_o     = |live;
        deliver_o = '0;
        if (rd_i) begin
            if (live[CH_OTHER])     deliver_o[CH_OTHER] = 1'b1;
            else if (live[CH_SELF]) deliver_o[CH_SELF]  = 1'b1;
        end
    end
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
    import ipi_pkg::*;
#(
    parameter int N      = 4,
    parameter int ADDR_W = 16,
    localparam int CW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        bus_valid,
    input  logic [N-1:0]        bus_write,
    input  logic [N*ADDR_W-1:0] bus_addr,
    input  logic [N*WORD_W-1:0] bus_wdata,
    output logic [N*WORD_W-1:0] bus_rdata,
    output logic [N-1:0]        irq_o
);
    logic [1:0]        dec_set  [N][N];
    logic [1:0]        dec_clr  [N][N];
    logic [1:0]        dec_mset [N][N];
    logic [1:0]        dec_mclr [N][N];
    logic [N-1:0]      dec_rd   [N];
    logic [N-1:0]      dec_hit;
    logic [CW-1:0]     dec_tgt  [N];

    logic [1:0]        set_d  [N];
    logic [1:0]        clr_d  [N];
    logic [1:0]        mset_d [N];
    logic [1:0]        mclr_d [N];
    logic [N-1:0]      rd_d;
    logic [1:0]        deliver [N];
    logic [1:0]        pend_q [N];
    logic [1:0]        mask_q [N];
    logic [WORD_W-1:0] ev_word [N];

    for (genvar p = 0; p < N; p++) begin : g_port
        ipi_port_decode #(.N(N), .ADDR_W(ADDR_W), .PORT(p)) u_dec (
            .valid_i   (bus_valid[p]),
            .write_i   (bus_write[p]),
            .addr_i    (bus_addr[p*ADDR_W +: ADDR_W]),
            .wdata_i   (bus_wdata[p*WORD_W +: WORD_W]),
            .set_o     (dec_set[p]),
            .clr_o     (dec_clr[p]),
            .mset_o    (dec_mset[p]),
            .mclr_o    (dec_mclr[p]),
            .evt_rd_o  (dec_rd[p]),
            .evt_hit_o (dec_hit[p]),
            .evt_tgt_o (dec_tgt[p])
        );
    end

    // merge the requests of all ports onto each target processor
    always_comb begin
        for (int c = 0; c < N; c++) begin
            set_d[c]  = '0;
            clr_d[c]  = '0;
            mset_d[c] = '0;
            mclr_d[c] = '0;
            rd_d[c]   = 1'b0;
            for (int p = 0; p < N; p++) begin
                set_d[c]  = set_d[c]  | dec_set[p][c];
                clr_d[c]  = clr_d[c]  | dec_clr[p][c];
                mset_d[c] = mset_d[c] | dec_mset[p][c];
                mclr_d[c] = mclr_d[c] | dec_mclr[p][c];
                rd_d[c]   = rd_d[c]   | dec_rd[p][c];
            end
        end
    end

    for (genvar c = 0; c < N; c++) begin : g_cpu
        ipi_chan_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_d[c]),
            .clr_i     (clr_d[c]),
            .mset_i    (mset_d[c]),
            .mclr_i    (mclr_d[c]),
            .deliver_i (deliver[c]),
            .pend_o    (pend_q[c]),
            .mask_o    (mask_q[c])
        );
        ipi_evt_sel u_sel (
            .pend_i    (pend_q[c]),
            .mask_i    (mask_q[c]),
            .rd_i      (rd_d[c]),
            .word_o    (ev_word[c]),
            .deliver_o (deliver[c]),
            .irq_o     (irq_o[c])
        );

        p_irq_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[c] |-> (ev_word[c][31:16] == EVT_KIND_IPI));
        p_one_deliver_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(deliver[c]));
        p_other_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (deliver[c][CH_SELF]) |-> !(pend_q[c][CH_OTHER] && !mask_q[c][CH_OTHER]));
    end

    always_comb begin
        for (int p = 0; p < N; p++) begin
            bus_rdata[p*WORD_W +: WORD_W] = dec_hit[p] ? ev_word[dec_tgt[p]] : '0;
        end
    end
endmodule

// File: tb/test_ipi_unit.sv
module test_ipi_unit;
    localparam int  N  = 4;
    localparam int  AW = 16;
    localparam time CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    bus_valid = '0;
    logic [N-1:0]    bus_write = '0;
    logic [N*AW-1:0] bus_addr  = '0;
    logic [N*32-1:0] bus_wdata = '0;
    logic [N*32-1:0] bus_rdata;
    logic [N-1:0]    irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    ipi_unit #(.N(N), .ADDR_W(AW)) i_ipi_unit (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [1:0]  port;
        logic        wr;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic [3:0]  exp_irq;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 16'h2028, 32'h8000_0001, 32'h0,         4'b0000, 8'd8},  // R8 unmask cpu0
        '{2'd1, 1'b1, 16'h2028, 32'h0000_0001, 32'h0,         4'b0000, 8'd8},  // R8 unmask cpu1 other
        '{2'd2, 1'b1, 16'h5128, 32'h8000_0001, 32'h0,         4'b0000, 8'd9},  // R9 explicit unmask cpu2
        '{2'd0, 1'b1, 16'h2008, 32'h0000_0006, 32'h0,         4'b0110, 8'd2},  // R2 send to cpu1, cpu2
        '{2'd1, 1'b0, 16'h2004, 32'h0,         32'h0004_0001, 4'b0100, 8'd6},  // R4 R6 read masks
        '{2'd1, 1'b0, 16'h2004, 32'h0,         32'h0,         4'b0100, 8'd6},  // R6 masked -> nothing
        '{2'd1, 1'b1, 16'h200C, 32'h0000_0001, 32'h0,         4'b0100, 8'd7},  // R7 ack cpu1
        '{2'd1, 1'b1, 16'h2028, 32'h0000_0001, 32'h0,         4'b0100, 8'd6},  // R6 re-enable, no pending
        '{2'd2, 1'b1, 16'h2008, 32'h8000_0000, 32'h0,         4'b0100, 8'd3},  // R3 self on cpu2
        '{2'd2, 1'b0, 16'h2004, 32'h0,         32'h0004_0001, 4'b0100, 8'd5},  // R5 other first
        '{2'd2, 1'b0, 16'h2004, 32'h0,         32'h0004_0002, 4'b0000, 8'd4},  // R4 self code
        '{2'd3, 1'b1, 16'h510C, 32'h8000_0001, 32'h0,         4'b0000, 8'd9},  // R9 explicit ack cpu2
        '{2'd2, 1'b1, 16'h5128, 32'h8000_0001, 32'h0,         4'b0000, 8'd7},  // R7 nothing left
        '{2'd3, 1'b1, 16'h5008, 32'h8000_0000, 32'h0,         4'b0001, 8'd3},  // R3 explicit set cpu0
        '{2'd0, 1'b1, 16'h2024, 32'h8000_0000, 32'h0,         4'b0000, 8'd8},  // R8 mask-set
        '{2'd0, 1'b0, 16'h2004, 32'h0,         32'h0,         4'b0000, 8'd8},  // R8 hidden
        '{2'd0, 1'b1, 16'h2028, 32'h8000_0000, 32'h0,         4'b0001, 8'd8},  // R8 reappears
        '{2'd3, 1'b0, 16'h5004, 32'h0,         32'h0004_0002, 4'b0000, 8'd9},  // R9 explicit event cpu0
        '{2'd0, 1'b1, 16'h200C, 32'h8000_0000, 32'h0,         4'b0000, 8'd7},  // R7 ack self
        '{2'd1, 1'b1, 16'h5208, 32'h8000_0001, 32'h0,         4'b0000, 8'd9},  // R9 cpu 4 out of range
        '{2'd0, 1'b1, 16'h2008, 32'h0000_0001, 32'h0,         4'b0001, 8'd2},  // R2 send to self index
        '{2'd0, 1'b1, 16'h200C, 32'h0000_0001, 32'h0,         4'b0000, 8'd11}  // R11 line drops
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input int p, input bit w, input logic [15:0] a,
                          input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        bus_valid[p] = 1'b1;
        bus_write[p] = w;
        bus_addr[p*AW +: AW] = a;
        bus_wdata[p*32 +: 32] = d;
        #1 rd = bus_rdata[p*32 +: 32];
        @(posedge clk);
        #1;
        bus_valid[p] = 1'b0;
        bus_write[p] = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        check("R1 irq after reset", 32'(irq_o), 32'h0);
        for (int p = 0; p < N; p++) begin
            access(p, 1'b0, 16'h2004, 32'h0, rd);
            check("R1 event after reset", rd, 32'h0);
        end
        access(0, 1'b1, 16'h2008, 32'h0000_0008, rd);
        check("R1 masked by default", 32'(irq_o), 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(int'(VECS[i].port), VECS[i].wr, VECS[i].addr, VECS[i].wdata, rd);
            total++;
            if (rd !== VECS[i].exp_rd || irq_o !== VECS[i].exp_irq) begin
                bad++;
                $display("FAIL R%0d step %0d actual rd=%h irq=%b expected rd=%h irq=%b",
                         VECS[i].req, i, rd, irq_o, VECS[i].exp_rd, VECS[i].exp_irq);
            end
        end

        // R8: request pending since the reset test becomes live on unmask
        access(3, 1'b1, 16'h2028, 32'h0000_0001, rd);
        check("R8 unmask reveals cpu3", 32'(irq_o), 32'h8);

        // R10: send and acknowledge in the same cycle
        @(negedge clk);
        bus_valid = 4'b1001;
        bus_write = 4'b1001;
        bus_addr[0*AW +: AW] = 16'h2008;
        bus_wdata[0*32 +: 32] = 32'h0000_0008;
        bus_addr[3*AW +: AW] = 16'h200C;
        bus_wdata[3*32 +: 32] = 32'h0000_0001;
        @(posedge clk);
        #1;
        bus_valid = '0;
        bus_write = '0;
        check("R10 collision keeps pending", 32'(irq_o), 32'h8);
        access(3, 1'b0, 16'h2004, 32'h0, rd);
        check("R10 event still reported", rd, 32'h0004_0001);

        // R7: plain acknowledge clears it
        access(3, 1'b1, 16'h200C, 32'h0000_0001, rd);
        access(3, 1'b1, 16'h2028, 32'h0000_0001, rd);
        check("R7 ack then unmask leaves nothing", 32'(irq_o), 32'h0);

        finish_run();
    end
endmodule